// File: doc/BRIEF.md
# Chunked Memory Transfer Sequencer

This block performs one read or one write over a byte-addressed memory port whose data path is narrower than the request. A request names a direction, a starting byte address and a length, from zero up to a fixed maximum. A rising edge on the start input begins the request. The block then issues a run of memory commands, one at a time. Each command carries its own byte address and byte count, and no command moves more bytes than the port width. When the last command has been taken, the block raises a single-cycle done pulse.

For a write, the block copies the caller's write data into an internal staging register when the request begins. Each command then presents the slice of that register that matches its position in the transfer. For a read, the block clears its result register when the request begins. Each returned beat is placed into the result register at the position of the bytes already moved. A command is held unchanged until the memory raises ready. One command is in flight at most. The next one appears in the cycle right after the ready.

Top module: `chunk_seq`

## Requirements
- R1: After reset, mem_cmd, mem_write and done are 0, mem_size is 0 and rd_data is all zero.
- R2: A request begins only on a rising edge of start seen while no request is in progress. Holding start high starts nothing further. A rising edge during a transfer is ignored.
- R3: While mem_cmd is 1 and mem_ready is 0, mem_cmd, mem_write, mem_addr, mem_size and mem_wdata keep their values into the next cycle.
- R4: mem_size equals the smaller of the remaining byte count and PORT_BYTES. It is 0 whenever mem_cmd is 0. The sizes of all accepted commands add up to the request length.
- R5: The first command's mem_addr is req_addr. After each accepted command, mem_addr grows by that command's mem_size.
- R6: mem_write is 1 on every command of a write request and 0 on every command of a read request. It is 0 while no command is presented.
- R7: For a write, lane j of mem_wdata (bits 8j+7..8j) holds staging byte (bytes already moved + j) for j below mem_size. The staging byte k is wr_data bits 8k+7..8k, captured at the start edge. All other lanes are 0, and mem_wdata is 0 during reads and when idle.
- R8: rd_data is cleared when a request is accepted. For a read, lanes 0..mem_size-1 of mem_rdata in an accepted command go to rd_data bytes (bytes already moved + lane). Lanes at or above mem_size and bytes past the length are not stored.
- R9: done is 1 for exactly one cycle, in the cycle after the final command is accepted, and no command is presented in that cycle. A rising start edge in that done cycle is accepted as a new request.
- R10: A zero-length request raises done in the cycle after the start edge and issues no memory command.
- R11: mem_cmd is 1 from the cycle after an accepted start edge until the final command is accepted. After a non-final ready, the next command is presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request trigger, acts on its rising edge |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | ADDR_W | First byte address of the request |
| req_len | input | $clog2(MAX_BYTES+1) | Request length in bytes |
| wr_data | input | 8*MAX_BYTES | Write bytes, byte k at bits 8k+7..8k |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8*MAX_BYTES | Assembled read result, byte k at bits 8k+7..8k |
| mem_cmd | output | 1 | A memory command is presented |
| mem_write | output | 1 | Command is a write (1) or a read (0) |
| mem_addr | output | ADDR_W | Byte address of the command |
| mem_size | output | $clog2(PORT_BYTES+1) | Byte count of the command |
| mem_ready | input | 1 | Memory takes the command in this cycle |
| mem_rdata | input | 8*PORT_BYTES | Read beat from memory |
| mem_wdata | output | 8*PORT_BYTES | Write beat to memory |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the final command's ready and a fresh rising edge on start. That edge must be ignored, because the sequencer is still busy at that clock. The second pair is the done pulse and a new rising edge. That edge must start a second transfer at once. The bench provokes both on purpose. It raises start in exactly the cycle where its model expects the last ready, and in a later run in the cycle where its model shows done. A cycle-accurate reference compares every output on every clock. It judges whether a second burst of commands follows, and whether it starts in the cycle after done.

// File: rtl/cs_pkg.sv
package cs_pkg;

    // control state: 0 is idle/final, 1 is the working state entered on start
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_state_e;

    // bytes carried by the next command
    function automatic int unsigned chunk_len(input int unsigned remaining,
                                              input int unsigned port_bytes);
        return (remaining < port_bytes) ? remaining : port_bytes;
    endfunction

endpackage

// File: rtl/cs_start_detect.sv
module cs_start_detect (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic rise
);
    logic start_q;

    always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b0;
        else     start_q <= start;
    end

    assign rise = start & ~start_q;
endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl
    import cs_pkg::*;
#(
    parameter int PORT_BYTES = 16,
    parameter int MAX_BYTES  = 64,
    parameter int ADDR_W     = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [$clog2(MAX_BYTES+1)-1:0] req_len,
    input  logic                mem_ready,
    output logic                mem_cmd,
    output logic                mem_write,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [$clog2(PORT_BYTES+1)-1:0] mem_size,
    output logic [((MAX_BYTES+PORT_BYTES-1)/PORT_BYTES > 1 ? $clog2((MAX_BYTES+PORT_BYTES-1)/PORT_BYTES) : 1)-1:0] chunk_idx,
    output logic                accept,
    output logic                load,
    output logic                done
);
    localparam int LEN_W  = $clog2(MAX_BYTES + 1);
    localparam int SZ_W   = $clog2(PORT_BYTES + 1);
    localparam int NCHUNK = (MAX_BYTES + PORT_BYTES - 1) / PORT_BYTES;
    localparam int IDX_W  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [IDX_W-1:0]  idx_q;
    logic              wr_q;
    logic              done_q;
    logic [SZ_W-1:0]   size_c;
    logic              last_c;
    logic              idle_c;

    assign idle_c = (state_q == ST_IDLE);
    assign size_c = SZ_W'(chunk_len(32'(rem_q), PORT_BYTES));
    assign last_c = (32'(rem_q) == 32'(size_c));
    assign accept = (state_q == ST_XFER) && mem_ready;
    assign load   = go && idle_c && (req_len != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            idx_q   <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        if (req_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_XFER;
                            addr_q  <= req_addr;
                            rem_q   <= req_len;
                            idx_q   <= '0;
                            wr_q    <= req_write;
                        end
                    end
                end
                ST_XFER: begin
                    if (mem_ready) begin
                        addr_q <= addr_q + ADDR_W'(size_c);
                        rem_q  <= rem_q - LEN_W'(size_c);
                        idx_q  <= idx_q + 1'b1;
                        if (last_c) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_cmd   = (state_q == ST_XFER);
    assign mem_write = wr_q & mem_cmd;
    assign mem_addr  = addr_q;
    assign mem_size  = mem_cmd ? size_c : '0;
    assign chunk_idx = idx_q;
    assign done      = done_q;

    // R3: a command not yet taken stays unchanged
    a_r3_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd && !mem_ready) |=> (mem_cmd && $stable(mem_addr) && $stable(mem_size) && $stable(mem_write)));

    // R4: every presented command moves between one byte and the port width
    a_r4_size_range: assert property (@(posedge clk) disable iff (rst)
        mem_cmd |-> (mem_size != '0 && mem_size <= SZ_W'(PORT_BYTES)));

    // R5: the address steps by the size just accepted
    a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
        (accept && !last_c) |=> (mem_cmd && mem_addr == $past(mem_addr) + ADDR_W'($past(mem_size))));

    // R9: final acceptance is followed by done with no command
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (accept && last_c) |=> (done && !mem_cmd));

    // R9: done lasts one cycle unless a new zero-length request arrives
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        (done && !go) |=> !done);

    // R10: an empty request finishes at once without touching memory
    a_r10_zero_len: assert property (@(posedge clk) disable iff (rst)
        (go && idle_c && req_len == '0) |=> (done && !mem_cmd));
endmodule

// File: rtl/cs_data_path.sv
module cs_data_path #(
    parameter int PORT_BYTES = 16,
    parameter int MAX_BYTES  = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [8*MAX_BYTES-1:0]      wr_data,
    input  logic                        cmd,
    input  logic                        is_write,
    input  logic                        accept,
    input  logic [((MAX_BYTES+PORT_BYTES-1)/PORT_BYTES > 1 ? $clog2((MAX_BYTES+PORT_BYTES-1)/PORT_BYTES) : 1)-1:0] chunk_idx,
    input  logic [$clog2(PORT_BYTES+1)-1:0] size,
    input  logic [8*PORT_BYTES-1:0]     mem_rdata,
    output logic [8*PORT_BYTES-1:0]     mem_wdata,
    output logic [8*MAX_BYTES-1:0]      rd_data
);
    localparam int SZ_W   = $clog2(PORT_BYTES + 1);
    localparam int NCHUNK = (MAX_BYTES + PORT_BYTES - 1) / PORT_BYTES;
    localparam int IDX_W  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
    localparam int STG_N  = NCHUNK * PORT_BYTES;
    localparam int SI_W   = (STG_N > 1) ? $clog2(STG_N) : 1;

    logic [7:0] stage_q [STG_N];
    logic [7:0] rd_q    [MAX_BYTES];

    // staging copy, padded to whole chunks
    for (genvar i = 0; i < STG_N; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[i] <= 8'h00;
            end else if (load) begin
                if (i < MAX_BYTES) stage_q[i] <= wr_data[(i % MAX_BYTES)*8 +: 8];
                else               stage_q[i] <= 8'h00;
            end
        end
    end

    // write lanes pick from the current chunk
    for (genvar j = 0; j < PORT_BYTES; j++) begin : g_wlane
        always_comb begin
            if (cmd && is_write && (SZ_W'(j) < size))
                mem_wdata[j*8 +: 8] = stage_q[SI_W'(int'(chunk_idx) * PORT_BYTES + j)];
            else
                mem_wdata[j*8 +: 8] = 8'h00;
        end
    end

    // each result byte belongs to one fixed chunk and lane
    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_rbyte
        localparam int CI = i / PORT_BYTES;
        localparam int LN = i % PORT_BYTES;
        always_ff @(posedge clk) begin
            if (rst || load) begin
                rd_q[i] <= 8'h00;
            end else if (accept && !is_write && chunk_idx == IDX_W'(CI) && SZ_W'(LN) < size) begin
                rd_q[i] <= mem_rdata[LN*8 +: 8];
            end
        end
        assign rd_data[i*8 +: 8] = rd_q[i];
    end

    // R3: write beat is held while the command waits
    a_r3_wdata_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd && !accept) |=> $stable(mem_wdata));

    // R8: the result starts empty for each accepted request
    a_r8_clear_on_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (rd_q[0] == 8'h00));
endmodule

// File: rtl/chunk_seq.sv
module chunk_seq #(
    parameter int PORT_BYTES = 16,
    parameter int MAX_BYTES  = 64,
    parameter int ADDR_W     = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic                              req_write,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [$clog2(MAX_BYTES+1)-1:0]    req_len,
    input  logic [8*MAX_BYTES-1:0]            wr_data,
    output logic                              done,
    output logic [8*MAX_BYTES-1:0]            rd_data,
    output logic                              mem_cmd,
    output logic                              mem_write,
    output logic [ADDR_W-1:0]                 mem_addr,
    output logic [$clog2(PORT_BYTES+1)-1:0]   mem_size,
    input  logic                              mem_ready,
    input  logic [8*PORT_BYTES-1:0]           mem_rdata,
    output logic [8*PORT_BYTES-1:0]           mem_wdata
);
    localparam int NCHUNK = (MAX_BYTES + PORT_BYTES - 1) / PORT_BYTES;
    localparam int IDX_W  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;

    logic             go;
    logic             accept;
    logic             load;
    logic [IDX_W-1:0] chunk_idx;

    cs_start_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .rise  (go)
    );

    cs_seq_ctrl #(
        .PORT_BYTES (PORT_BYTES),
        .MAX_BYTES  (MAX_BYTES),
        .ADDR_W     (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .mem_ready (mem_ready),
        .mem_cmd   (mem_cmd),
        .mem_write (mem_write),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .chunk_idx (chunk_idx),
        .accept    (accept),
        .load      (load),
        .done      (done)
    );

    cs_data_path #(
        .PORT_BYTES (PORT_BYTES),
        .MAX_BYTES  (MAX_BYTES)
    ) u_data (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .wr_data   (wr_data),
        .cmd       (mem_cmd),
        .is_write  (mem_write),
        .accept    (accept),
        .chunk_idx (chunk_idx),
        .size      (mem_size),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .rd_data   (rd_data)
    );
endmodule

// File: tb/chunk_seq_bench.sv
`timescale 1ns/1ps
module chunk_seq_bench;
    localparam int P  = 16;
    localparam int M  = 64;
    localparam int AW = 32;
    localparam int LW = $clog2(M + 1);
    localparam int SW = $clog2(P + 1);

    logic            clk = 1'b0;
    logic            rst;
    logic            start;
    logic            req_write;
    logic [AW-1:0]   req_addr;
    logic [LW-1:0]   req_len;
    logic [8*M-1:0]  wr_data;
    logic            done;
    logic [8*M-1:0]  rd_data;
    logic            mem_cmd;
    logic            mem_write;
    logic [AW-1:0]   mem_addr;
    logic [SW-1:0]   mem_size;
    logic            mem_ready;
    logic [8*P-1:0]  mem_rdata;
    logic [8*P-1:0]  mem_wdata;

    always #2.5 clk = ~clk;

    chunk_seq #(.PORT_BYTES(P), .MAX_BYTES(M), .ADDR_W(AW)) u_chunk_seq (
        .clk(clk), .rst(rst), .start(start), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data),
        .done(done), .rd_data(rd_data), .mem_cmd(mem_cmd),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference
    int          m_busy, m_done, m_prev, m_wr, m_rem, m_off;
    logic [31:0] m_addr;
    logic [7:0]  m_stage [M];
    logic [7:0]  m_rd    [M];
    logic [7:0]  mem_b   [256];

    int          rmode;
    logic        tog;
    logic [7:0]  lf;
    int          poke_busy, poke_done, pokes_seen;

    // previous-cycle observations for the hold check
    logic            p_valid;
    logic            p_cmd, p_rdy, p_wr;
    logic [AW-1:0]   p_addr;
    logic [SW-1:0]   p_size;
    logic [8*P-1:0]  p_wdata;

    task automatic chk(input string tag, input string what,
                       input logic [8*M-1:0] act, input logic [8*M-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int min_sz(input int r);
        return (r < P) ? r : P;
    endfunction

    task automatic compare_all();
        logic [8*P-1:0] ew;
        logic [8*M-1:0] er;
        int sz;
        sz = m_busy ? min_sz(m_rem) : 0;
        ew = '0;
        if (m_busy && m_wr)
            for (int j = 0; j < sz; j++) ew[j*8 +: 8] = m_stage[m_off + j];
        for (int i = 0; i < M; i++) er[i*8 +: 8] = m_rd[i];
        chk("R11", "mem_cmd", (8*M)'(mem_cmd), (8*M)'(m_busy != 0));
        chk("R4", "mem_size", (8*M)'(mem_size), (8*M)'(sz));
        chk("R6", "mem_write", (8*M)'(mem_write), (8*M)'(m_busy != 0 && m_wr != 0));
        if (m_busy) chk("R5", "mem_addr", (8*M)'(mem_addr), (8*M)'(m_addr));
        chk("R7", "mem_wdata", (8*M)'(mem_wdata), (8*M)'(ew));
        chk("R8", "rd_data", rd_data, er);
        chk("R9", "done", (8*M)'(done), (8*M)'(m_done != 0));
        if (p_valid && p_cmd && !p_rdy) begin
            chk("R3", "held cmd", (8*M)'(mem_cmd), (8*M)'(1'b1));
            chk("R3", "held addr", (8*M)'(mem_addr), (8*M)'(p_addr));
            chk("R3", "held size", (8*M)'(mem_size), (8*M)'(p_size));
            chk("R3", "held write", (8*M)'(mem_write), (8*M)'(p_wr));
            chk("R3", "held wdata", (8*M)'(mem_wdata), (8*M)'(p_wdata));
        end
    endtask

    task automatic model_update(input logic st, input logic rdy);
        int nd;
        int sz;
        logic rise;
        rise   = st && !m_prev;
        m_prev = st;
        nd     = 0;
        if (!m_busy) begin
            if (rise) begin
                if (req_len == 0) begin
                    nd = 1;
                end else begin
                    m_busy = 1;
                    m_addr = req_addr;
                    m_rem  = int'(req_len);
                    m_off  = 0;
                    m_wr   = req_write;
                    for (int i = 0; i < M; i++) begin
                        m_rd[i]    = 8'h00;
                        m_stage[i] = wr_data[i*8 +: 8];
                    end
                end
            end
        end else if (rdy) begin
            sz = min_sz(m_rem);
            for (int j = 0; j < sz; j++) begin
                if (m_wr) mem_b[(m_addr + j) % 256] = m_stage[m_off + j];
                else      m_rd[m_off + j] = mem_b[(m_addr + j) % 256];
            end
            m_off  = m_off + sz;
            m_addr = m_addr + sz;
            m_rem  = m_rem - sz;
            if (m_rem == 0) begin
                m_busy = 0;
                nd = 1;
            end
        end
        m_done = nd;
    endtask

    task automatic step(input logic st_in);
        logic st;
        logic rdy;
        logic [8*P-1:0] rd;
        int sz;
        @(negedge clk);
        compare_all();
        p_valid = 1'b1;
        p_cmd   = mem_cmd;
        p_addr  = mem_addr;
        p_size  = mem_size;
        p_wr    = mem_write;
        p_wdata = mem_wdata;
        tog = ~tog;
        lf  = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        case (rmode)
            0:       rdy = 1'b1;
            1:       rdy = tog;
            default: rdy = lf[0] | lf[2];
        endcase
        st = st_in;
        // final ready and a fresh start edge in the same cycle
        if (poke_busy != 0 && m_busy != 0 && m_rem <= P && rdy && !m_prev) begin
            st = 1'b1; poke_busy = 0; pokes_seen++;
        end
        // start edge in the done cycle
        if (poke_done != 0 && m_done != 0 && !m_prev) begin
            st = 1'b1; poke_done = 0; pokes_seen++;
        end
        sz = m_busy ? min_sz(m_rem) : 0;
        rd = '1;
        for (int j = 0; j < P; j++)
            rd[j*8 +: 8] = (j < sz) ? mem_b[(m_addr + j) % 256] : 8'hEE;
        start     = st;
        mem_ready = rdy;
        mem_rdata = rd;
        p_rdy     = rdy;
        model_update(st, rdy);
    endtask

    task automatic peek();
        #3.5;
    endtask

    task automatic set_req(input logic w, input logic [AW-1:0] a, input int len, input int seed);
        req_write = w;
        req_addr  = a;
        req_len   = LW'(len);
        for (int i = 0; i < M; i++) wr_data[i*8 +: 8] = 8'((seed + i * 13) & 255);
    endtask

    task automatic run_req(input logic w, input logic [AW-1:0] a, input int len,
                           input int mode, input int seed, input logic hold);
        rmode = mode;
        set_req(w, a, len, seed);
        step(1'b1);
        for (int k = 0; k < 600 && (m_busy != 0 || m_done != 0); k++) step(hold);
        step(hold);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL R9 watchdog: actual no completion expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; mem_ready = 1'b0; mem_rdata = '0;
        set_req(1'b0, '0, 0, 0);
        m_busy = 0; m_done = 0; m_prev = 0; m_wr = 0; m_rem = 0; m_off = 0; m_addr = '0;
        for (int i = 0; i < M; i++) begin m_stage[i] = 8'h00; m_rd[i] = 8'h00; end
        for (int i = 0; i < 256; i++) mem_b[i] = 8'((i * 7 + 3) ^ 8'h5A);
        rmode = 0; tog = 1'b0; lf = 8'hA7;
        poke_busy = 0; poke_done = 0; pokes_seen = 0; p_valid = 1'b0;
        p_cmd = 1'b0; p_rdy = 1'b0; p_wr = 1'b0; p_addr = '0; p_size = '0; p_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        peek();
        // R1: state after reset
        chk("R1", "mem_cmd", (8*M)'(mem_cmd), '0);
        chk("R1", "done", (8*M)'(done), '0);
        chk("R1", "mem_size", (8*M)'(mem_size), '0);
        chk("R1", "mem_write", (8*M)'(mem_write), '0);
        chk("R1", "rd_data", rd_data, '0);

        // R4 R5 R7 R11: multi-chunk write, memory always ready
        run_req(1'b1, 32'h10, 40, 0, 17, 1'b0);
        // R3 R8: read back with ready every other cycle
        run_req(1'b0, 32'h10, 40, 1, 0, 1'b0);
        // R4: exactly one full chunk, irregular ready
        run_req(1'b0, 32'h80, 16, 2, 0, 1'b0);
        // R4 R8: single byte near the top of memory
        run_req(1'b0, 32'hF0, 1, 0, 0, 1'b0);
        // R6 R7: maximum length write
        run_req(1'b1, 32'h40, 64, 2, 91, 1'b0);
        run_req(1'b0, 32'h40, 64, 1, 0, 1'b0);

        // R10: empty request
        rmode = 0;
        set_req(1'b0, 32'h20, 0, 0);
        step(1'b1);
        peek();
        chk("R10", "done after empty start", (8*M)'(done), (8*M)'(1'b1));
        chk("R10", "no command on empty start", (8*M)'(mem_cmd), '0);
        step(1'b0);
        step(1'b0);

        // R2: start held high starts only one request
        run_req(1'b0, 32'h30, 20, 0, 0, 1'b1);
        for (int k = 0; k < 5; k++) begin
            step(1'b1);
            chk("R2", "no restart on held start", (8*M)'(mem_cmd), '0);
        end
        step(1'b0);

        // R2: start edge on the final ready is ignored
        poke_busy = 1;
        run_req(1'b0, 32'h50, 33, 1, 0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            step(1'b0);
            chk("R2", "edge during busy ignored", (8*M)'(mem_cmd), '0);
        end

        // R9: start edge in the done cycle begins a second transfer
        poke_done = 1;
        run_req(1'b1, 32'h60, 20, 0, 33, 1'b0);
        for (int k = 0; k < 200 && (m_busy != 0 || m_done != 0); k++) step(1'b0);
        step(1'b0);
        chk("R9", "both overlap cases provoked", (8*M)'(pokes_seen), (8*M)'(2));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule